// File: doc/BRIEF.md
# ADC Calibration and Conversion Sequencer

This block drives a sigma-delta converter through its operating modes by way of a register-access port. It does not shift serial bits. It places one register access at a time on that port, holds it until the engine acknowledges it, and then moves to the next access. When reset is released, the sequencer programs the mode register and then the configuration register. It then runs an eight-step internal calibration sweep, parks the converter in idle mode and waits for requests.

Three kinds of request are accepted while the block is idle:

- A single conversion on a chosen channel. The result comes back on a data output with a one-cycle valid strobe.
- A gain update. It triggers a configuration write and a full recalibration, but only when the gain actually changes.
- A new filter word. It is checked against the legal range before it is written.

Requests that arrive while a sequence is running are refused with a reject strobe. If the converter does not signal ready within a bounded number of cycles, the sequence is abandoned. The converter is then returned to idle and a sticky error flag is raised.

Top module: `adc_cal_sequencer`

## Requirements
- R1: After reset the first access writes the mode register (address 1) with select field bits 23:21 = 2 (idle), clock source in bits 19:18 and filter word 480 in bits 9:0. The second access writes the configuration register (address 2) with no channel bit set in 15:8, the unipolar strap in bit 3 and gain 0 in bits 2:0.
- R2: The calibration sweep has eight steps on channels 4,4,5,5,6,6,7,7. Even steps use select 4 (zero-scale) and odd steps use select 5 (full-scale). Each step writes the configuration register with a one-hot channel in bits 15:8, then writes the mode register, then waits for ready. The sweep ends with a mode write that selects idle (2).
- R3: `busy` is high from reset through the whole start-up sequence and through every request being served. It is low only when the block can accept a request.
- R4: A conversion request on channel c writes the configuration register with bit 8+c set. It then writes the mode register with select 1, waits for ready and reads address 3. On the cycle after that read is acknowledged, `conv_valid` pulses for one cycle with the read word on `conv_data`.
- R5: A gain request whose value equals the current gain makes no register access. A different gain writes the configuration register (current channel, new gain) and then reruns the full R2 sweep with the new gain.
- R6: A filter-word request in the range 1..1023 writes the mode register with select idle and the new word in bits 9:0. Any other value (0 or above 1023) pulses `rate_rej` and makes no access, and later mode writes keep the previous word.
- R7: Any request that arrives while `busy` is high pulses `req_rej` on the following cycle and is otherwise ignored.
- R8: If ready does not arrive within RDY_TMO cycles of waiting, the step is abandoned, the mode register is written with select idle, `err` is set and the block returns to idle. No `conv_valid` is produced.
- R9: `err` stays set through later successful operations until reset clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_src | input | 2 | Clock-source code placed in mode bits 19:18 |
| unipolar | input | 1 | Unipolar strap placed in configuration bit 3 |
| conv_req | input | 1 | Single-conversion request strobe |
| conv_chan | input | 3 | Channel index for the conversion |
| gain_req | input | 1 | Gain-update request strobe |
| gain_val | input | 3 | Requested gain code |
| rate_req | input | 1 | Filter-word update request strobe |
| rate_val | input | 12 | Requested filter word |
| busy | output | 1 | Sequence in progress |
| err | output | 1 | Sticky ready-timeout flag |
| req_rej | output | 1 | Request refused because busy |
| rate_rej | output | 1 | Filter word out of range |
| conv_valid | output | 1 | Conversion result strobe |
| conv_data | output | 24 | Conversion result |
| reg_req | output | 1 | Register access pending |
| reg_wr | output | 1 | Access is a write |
| reg_addr | output | 3 | Register address |
| reg_wdata | output | 24 | Write data |
| reg_ack | input | 1 | Engine finished the access |
| reg_rdata | input | 24 | Read data, valid with reg_ack |
| adc_rdy | input | 1 | Converter ready level |

## Verification
The bench logs every access taken by a modelled engine and compares the complete ordered list against lists it builds from the register layouts. An off-by-one in the step order, a zero/full-scale swap or a missing park write therefore shows up as a wrong entry. The filter-word walk probes 0, 1, 1023, 1024 and 4095. A range check with the wrong bounds either writes a word it should refuse or drops a legal one, and a later conversion shows whether a refused word leaked into the mode shadow. Repeating the current gain must produce no traffic, which catches a design that recalibrates unconditionally. A converter that never becomes ready must end in an idle write with `err` raised, and that flag must survive a following good conversion and clear only on reset.

// File: rtl/adcseq_pkg.sv
// Package: register layout constants, state encoding and word builders
// shared by the sequencer modules. Assumes the 24-bit mode and
// configuration word layouts given in the brief.
package adcseq_pkg;

    localparam int WORD_W  = 24;
    localparam int ADDR_W  = 3;
    localparam int CH_W    = 3;
    localparam int NCH     = 8;
    localparam int RATE_W  = 10;
    localparam int GAIN_W  = 3;

    localparam logic [ADDR_W-1:0] A_MODE = 3'd1;
    localparam logic [ADDR_W-1:0] A_CONF = 3'd2;
    localparam logic [ADDR_W-1:0] A_DATA = 3'd3;

    typedef enum logic [2:0] {
        OP_CONT    = 3'd0,
        OP_SINGLE  = 3'd1,
        OP_IDLE    = 3'd2,
        OP_PDOWN   = 3'd3,
        OP_CAL_IZ  = 3'd4,
        OP_CAL_IF  = 3'd5,
        OP_CAL_SZ  = 3'd6,
        OP_CAL_SF  = 3'd7
    } op_sel_e;

    typedef enum logic [3:0] {
        ST_INIT_MODE,
        ST_INIT_CONF,
        ST_CH,
        ST_MODE,
        ST_WAIT,
        ST_READ,
        ST_PARK,
        ST_ABORT,
        ST_IDLE,
        ST_GAIN,
        ST_RATE
    } seq_state_e;

    // Mode word: select 23:21, clock source 19:18, filter word 9:0.
    function automatic logic [WORD_W-1:0] mode_word(input op_sel_e sel,
                                                    input logic [1:0] csrc,
                                                    input logic [RATE_W-1:0] rate);
        return {sel, 1'b0, csrc, 8'b0, rate};
    endfunction

    // Configuration word: one-hot channel 15:8, unipolar 3, gain 2:0.
    function automatic logic [WORD_W-1:0] conf_word(input logic [NCH-1:0] oh,
                                                    input logic uni,
                                                    input logic [GAIN_W-1:0] gain);
        return {8'b0, oh, 4'b0, uni, gain};
    endfunction

endpackage

// File: rtl/adcseq_step_table.sv
// Calibration step decoder: maps a step index to the channel and the
// calibration select for that step. Steps come in pairs per channel,
// zero-scale first. Assumes STEPS is even.
module adcseq_step_table
    import adcseq_pkg::*;
#(
    parameter int STEPS    = 8,
    parameter int FIRST_CH = 4,
    localparam int IDX_W   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic [IDX_W-1:0] idx,
    output logic [CH_W-1:0]  chan,
    output op_sel_e          sel,
    output logic             last
);

    // Decode the step index into channel, select and last-step flag.
    always_comb begin
        chan = CH_W'(FIRST_CH) + CH_W'(idx >> 1);
        sel  = idx[0] ? OP_CAL_IF : OP_CAL_IZ;
        last = (idx == IDX_W'(STEPS - 1));
    end

endmodule

// File: rtl/adcseq_rate_check.sv
// Filter-word range check: flags a requested word as legal when it lies
// in 1..MAX_RATE. Pure combinational; assumes IN_W covers the widest
// value software may present.
module adcseq_rate_check #(
    parameter int IN_W     = 12,
    parameter int MAX_RATE = 1023
) (
    input  logic [IN_W-1:0] val,
    output logic            ok
);

    // Compare against both ends of the legal window.
    always_comb begin
        ok = (val != '0) && (val <= IN_W'(MAX_RATE));
    end

endmodule

// File: rtl/adcseq_wait_timer.sv
// Ready-wait timer: counts cycles while the sequencer waits for the
// converter and flags expiry after TMO cycles without ready.
// Assumes TMO >= 2.
module adcseq_wait_timer #(
    parameter int TMO   = 4096,
    localparam int CNT_W = $clog2(TMO + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);

    logic [CNT_W-1:0] cnt;

    // Count while waiting, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    // Expiry when the wait has lasted TMO cycles.
    always_comb expired = run && (cnt == CNT_W'(TMO - 1));

    p_tmo_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt < CNT_W'(TMO)));

endmodule

// File: rtl/adcseq_ctrl.sv
// Sequencer state machine: start-up programming, calibration sweep,
// single conversion, gain and filter-word updates, and timeout abort.
// Issues one register access at a time and holds it until reg_ack.
// Assumes reg_ack is a one-cycle pulse per access and reg_rdata is valid with it.
module adcseq_ctrl
    import adcseq_pkg::*;
#(
    parameter int STEPS     = 8,
    parameter int INIT_RATE = 480,
    localparam int IDX_W    = (STEPS > 1) ? $clog2(STEPS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          clk_src,
    input  logic                unipolar,
    input  logic                conv_req,
    input  logic [CH_W-1:0]     conv_chan,
    input  logic                gain_req,
    input  logic [GAIN_W-1:0]   gain_val,
    input  logic                rate_req,
    input  logic [RATE_W-1:0]   rate_new,
    input  logic                rate_ok,
    input  logic [CH_W-1:0]     step_chan,
    input  op_sel_e             step_sel,
    input  logic                step_last,
    input  logic                tmo_hit,
    input  logic                adc_rdy,
    input  logic                reg_ack,
    input  logic [WORD_W-1:0]   reg_rdata,
    output logic [IDX_W-1:0]    step_idx,
    output logic                wait_run,
    output logic                busy,
    output logic                err,
    output logic                req_rej,
    output logic                rate_rej,
    output logic                conv_valid,
    output logic [WORD_W-1:0]   conv_data,
    output logic                reg_req,
    output logic                reg_wr,
    output logic [ADDR_W-1:0]   reg_addr,
    output logic [WORD_W-1:0]   reg_wdata
);

    seq_state_e          state;
    logic                is_cal;
    logic [CH_W-1:0]     chan_q;
    logic [NCH-1:0]      chan_oh_q;
    logic [GAIN_W-1:0]   gain_q;
    logic [RATE_W-1:0]   rate_q;
    logic [CH_W-1:0]     tgt_chan;
    logic [NCH-1:0]      tgt_oh;
    logic                any_req;

    // Target channel for the current channel write.
    always_comb begin
        tgt_chan = is_cal ? step_chan : chan_q;
        tgt_oh   = NCH'(1) << tgt_chan;
        any_req  = conv_req || gain_req || rate_req;
        busy     = (state != ST_IDLE);
        wait_run = (state == ST_WAIT);
    end

    // Drive the register-access port from the current state.
    always_comb begin
        reg_req   = 1'b0;
        reg_wr    = 1'b1;
        reg_addr  = A_MODE;
        reg_wdata = '0;
        unique case (state)
            ST_INIT_MODE, ST_PARK, ST_ABORT, ST_RATE: begin
                reg_req   = 1'b1;
                reg_wdata = mode_word(OP_IDLE, clk_src, rate_q);
            end
            ST_INIT_CONF, ST_GAIN: begin
                reg_req   = 1'b1;
                reg_addr  = A_CONF;
                reg_wdata = conf_word(chan_oh_q, unipolar, gain_q);
            end
            ST_CH: begin
                reg_req   = 1'b1;
                reg_addr  = A_CONF;
                reg_wdata = conf_word(tgt_oh, unipolar, gain_q);
            end
            ST_MODE: begin
                reg_req   = 1'b1;
                reg_wdata = mode_word(is_cal ? step_sel : OP_SINGLE, clk_src, rate_q);
            end
            ST_READ: begin
                reg_req  = 1'b1;
                reg_wr   = 1'b0;
                reg_addr = A_DATA;
            end
            default: ;
        endcase
    end

    // Sequence state, shadows and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_INIT_MODE;
            is_cal     <= 1'b0;
            step_idx   <= '0;
            chan_q     <= '0;
            chan_oh_q  <= '0;
            gain_q     <= '0;
            rate_q     <= RATE_W'(INIT_RATE);
            err        <= 1'b0;
            req_rej    <= 1'b0;
            rate_rej   <= 1'b0;
            conv_valid <= 1'b0;
            conv_data  <= '0;
        end else begin
            req_rej    <= busy && any_req;
            rate_rej   <= 1'b0;
            conv_valid <= 1'b0;
            unique case (state)
                ST_INIT_MODE: if (reg_ack) state <= ST_INIT_CONF;
                ST_INIT_CONF, ST_GAIN: if (reg_ack) begin
                    state    <= ST_CH;
                    is_cal   <= 1'b1;
                    step_idx <= '0;
                end
                ST_CH: if (reg_ack) begin
                    chan_oh_q <= tgt_oh;
                    state     <= ST_MODE;
                end
                ST_MODE: if (reg_ack) state <= ST_WAIT;
                ST_WAIT: begin
                    if (adc_rdy) begin
                        if (!is_cal) begin
                            state <= ST_READ;
                        end else if (step_last) begin
                            state <= ST_PARK;
                        end else begin
                            step_idx <= step_idx + 1'b1;
                            state    <= ST_CH;
                        end
                    end else if (tmo_hit) begin
                        err   <= 1'b1;
                        state <= ST_ABORT;
                    end
                end
                ST_READ: if (reg_ack) begin
                    conv_data  <= reg_rdata;
                    conv_valid <= 1'b1;
                    state      <= ST_IDLE;
                end
                ST_PARK, ST_ABORT, ST_RATE: if (reg_ack) state <= ST_IDLE;
                ST_IDLE: begin
                    if (conv_req) begin
                        chan_q <= conv_chan;
                        is_cal <= 1'b0;
                        state  <= ST_CH;
                    end else if (gain_req) begin
                        if (conf_word(chan_oh_q, unipolar, gain_val)
                            != conf_word(chan_oh_q, unipolar, gain_q)) begin
                            gain_q <= gain_val;
                            state  <= ST_GAIN;
                        end
                    end else if (rate_req) begin
                        if (rate_ok) begin
                            rate_q <= rate_new;
                            state  <= ST_RATE;
                        end else begin
                            rate_rej <= 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // An access, once raised, holds its address and data until acknowledged.
    p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_ack) |=> (reg_req && $stable(reg_addr) && $stable(reg_wdata)));

    // Calibration mode writes carry only the internal zero/full-scale selects.
    p_cal_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && state == ST_MODE && is_cal)
            |-> (reg_wdata[23:21] == 3'd4 || reg_wdata[23:21] == 3'd5));

    // Requests during a sequence are refused on the next cycle.
    p_busy_rej_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && conv_req) |=> req_rej);

    // A refused filter word leaves the shadow untouched.
    p_rate_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rate_rej |-> $stable(rate_q));

    // The error flag never clears without reset.
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // A result strobe only appears once the block is idle again.
    p_valid_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_valid |-> !busy);

endmodule

// File: rtl/adc_cal_sequencer.sv
// Top level: ties the sequencing state machine to the calibration step
// decoder, the filter-word range check and the ready-wait timer.
// Assumes an external engine performs each register access on reg_*.
module adc_cal_sequencer
    import adcseq_pkg::*;
#(
    parameter int RDY_TMO      = 4096,
    parameter int INIT_RATE    = 480,
    parameter int CAL_STEPS    = 8,
    parameter int CAL_FIRST_CH = 4,
    parameter int RATE_IN_W    = 12,
    localparam int IDX_W       = (CAL_STEPS > 1) ? $clog2(CAL_STEPS) : 1,
    localparam int MAX_RATE    = (1 << RATE_W) - 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            clk_src,
    input  logic                  unipolar,
    input  logic                  conv_req,
    input  logic [2:0]            conv_chan,
    input  logic                  gain_req,
    input  logic [2:0]            gain_val,
    input  logic                  rate_req,
    input  logic [RATE_IN_W-1:0]  rate_val,
    output logic                  busy,
    output logic                  err,
    output logic                  req_rej,
    output logic                  rate_rej,
    output logic                  conv_valid,
    output logic [23:0]           conv_data,
    output logic                  reg_req,
    output logic                  reg_wr,
    output logic [2:0]            reg_addr,
    output logic [23:0]           reg_wdata,
    input  logic                  reg_ack,
    input  logic [23:0]           reg_rdata,
    input  logic                  adc_rdy
);

    logic [IDX_W-1:0] step_idx;
    logic [CH_W-1:0]  step_chan;
    op_sel_e          step_sel;
    logic             step_last;
    logic             rate_ok;
    logic             wait_run;
    logic             tmo_hit;

    adcseq_step_table #(.STEPS(CAL_STEPS), .FIRST_CH(CAL_FIRST_CH)) u_steps (
        .idx  (step_idx),
        .chan (step_chan),
        .sel  (step_sel),
        .last (step_last)
    );

    adcseq_rate_check #(.IN_W(RATE_IN_W), .MAX_RATE(MAX_RATE)) u_rate (
        .val (rate_val),
        .ok  (rate_ok)
    );

    adcseq_wait_timer #(.TMO(RDY_TMO)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (wait_run),
        .expired (tmo_hit)
    );

    adcseq_ctrl #(.STEPS(CAL_STEPS), .INIT_RATE(INIT_RATE)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clk_src    (clk_src),
        .unipolar   (unipolar),
        .conv_req   (conv_req),
        .conv_chan  (conv_chan),
        .gain_req   (gain_req),
        .gain_val   (gain_val),
        .rate_req   (rate_req),
        .rate_new   (rate_val[RATE_W-1:0]),
        .rate_ok    (rate_ok),
        .step_chan  (step_chan),
        .step_sel   (step_sel),
        .step_last  (step_last),
        .tmo_hit    (tmo_hit),
        .adc_rdy    (adc_rdy),
        .reg_ack    (reg_ack),
        .reg_rdata  (reg_rdata),
        .step_idx   (step_idx),
        .wait_run   (wait_run),
        .busy       (busy),
        .err        (err),
        .req_rej    (req_rej),
        .rate_rej   (rate_rej),
        .conv_valid (conv_valid),
        .conv_data  (conv_data),
        .reg_req    (reg_req),
        .reg_wr     (reg_wr),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata)
    );

endmodule

// File: tb/adc_cal_sequencer_tb.sv
// Bench: models the register engine and converter ready, logs every
// access, and compares the log against lists built from the requirements.
module adc_cal_sequencer_tb;

    localparam int TMO = 64;
    localparam logic [1:0] CSRC = 2'b10;
    localparam logic UNI = 1'b1;

    // Filter-word vectors: {value[12:1], accepted[0]}.
    localparam int NVEC = 8;
    localparam logic [12:0] RATE_VEC [NVEC] = '{
        {12'd0, 1'b0}, {12'd1, 1'b1}, {12'd1023, 1'b1}, {12'd1024, 1'b0},
        {12'd480, 1'b1}, {12'd4095, 1'b0}, {12'd77, 1'b1}, {12'd0, 1'b0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic conv_req = 1'b0, gain_req = 1'b0, rate_req = 1'b0;
    logic [2:0] conv_chan = '0, gain_val = '0;
    logic [11:0] rate_val = '0;
    logic busy, err, req_rej, rate_rej, conv_valid;
    logic [23:0] conv_data;
    logic reg_req, reg_wr, reg_ack;
    logic [2:0] reg_addr;
    logic [23:0] reg_wdata, reg_rdata;
    logic adc_rdy;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    adc_cal_sequencer #(.RDY_TMO(TMO)) u_dut (
        .clk(clk), .rst_n(rst_n), .clk_src(CSRC), .unipolar(UNI),
        .conv_req(conv_req), .conv_chan(conv_chan),
        .gain_req(gain_req), .gain_val(gain_val),
        .rate_req(rate_req), .rate_val(rate_val),
        .busy(busy), .err(err), .req_rej(req_rej), .rate_rej(rate_rej),
        .conv_valid(conv_valid), .conv_data(conv_data),
        .reg_req(reg_req), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_ack(reg_ack), .reg_rdata(reg_rdata),
        .adc_rdy(adc_rdy)
    );

    // Engine and converter model.
    logic [1:0] eng_cnt;
    logic [2:0] log_addr [256];
    logic [23:0] log_data [256];
    logic log_wr [256];
    int log_n;
    logic [23:0] last_conf;
    logic suppress_rdy = 1'b0;
    logic armed;
    logic [3:0] rdy_cnt;
    logic fire;

    assign fire = !reg_ack && reg_req && eng_cnt == 2'd2;
    assign reg_rdata = {8'hC3, last_conf[15:8], 8'h3C};

    always @(posedge clk) begin
        if (!rst_n) begin
            eng_cnt <= '0; reg_ack <= 1'b0; log_n <= 0; last_conf <= '0;
            adc_rdy <= 1'b0; armed <= 1'b0; rdy_cnt <= '0;
        end else begin
            if (reg_ack) begin
                reg_ack <= 1'b0; eng_cnt <= '0;
            end else if (reg_req) begin
                if (fire) begin
                    reg_ack <= 1'b1;
                    log_addr[log_n[7:0]] <= reg_addr;
                    log_data[log_n[7:0]] <= reg_wdata;
                    log_wr[log_n[7:0]] <= reg_wr;
                    log_n <= log_n + 1;
                    if (reg_wr && reg_addr == 3'd2) last_conf <= reg_wdata;
                end else eng_cnt <= eng_cnt + 1'b1;
            end else eng_cnt <= '0;

            if (fire && reg_wr && reg_addr == 3'd1) begin
                adc_rdy <= 1'b0;
                armed <= (reg_wdata[23:21] == 3'd1 || reg_wdata[23:21] == 3'd4 ||
                          reg_wdata[23:21] == 3'd5) && !suppress_rdy;
                rdy_cnt <= 4'd5;
            end else if (armed) begin
                if (rdy_cnt == 0) begin adc_rdy <= 1'b1; armed <= 1'b0; end
                else rdy_cnt <= rdy_cnt - 1'b1;
            end
        end
    end

    // Result monitor, sampled at the falling edge.
    int nvalid = 0;
    logic [23:0] last_data = '0;
    always @(negedge clk) if (rst_n && conv_valid) begin
        nvalid <= nvalid + 1; last_data <= conv_data;
    end

    function automatic logic [23:0] exp_mode(input int sel, input int rate);
        return 24'((sel << 21) | (int'(CSRC) << 18) | rate);
    endfunction

    function automatic logic [23:0] exp_conf(input int ch, input int gain);
        int oh;
        oh = (ch < 0) ? 0 : (1 << ch);
        return 24'((oh << 8) | (int'(UNI) << 3) | gain);
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_wr(input int i, input logic [2:0] a, input logic [23:0] d,
                            input string req);
        check(log_wr[i] == 1'b1 && log_addr[i] == a && log_data[i] == d, req,
              $sformatf("access %0d", i), {log_wr[i], 4'b0, log_addr[i], log_data[i]},
              {1'b1, 4'b0, a, d});
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 5000; k++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic sweep_expect(input int base, input int gain, input int rate,
                                input string req);
        for (int k = 0; k < 8; k++) begin
            check_wr(base + 2*k, 3'd2, exp_conf(4 + k/2, gain), req);
            check_wr(base + 2*k + 1, 3'd1, exp_mode((k % 2) ? 5 : 4, rate), req);
        end
        check_wr(base + 16, 3'd1, exp_mode(2, rate), req);
    endtask

    task automatic do_conv(input int ch, input int gain, input int rate, input bit good);
        int base, nv0;
        base = log_n; nv0 = nvalid;
        @(negedge clk); conv_chan = 3'(ch); conv_req = 1'b1;
        @(negedge clk); conv_req = 1'b0;
        wait_idle();
        @(negedge clk);
        check(log_n - base == 3, "R4", "access count", 32'(log_n - base), 32'd3);
        check_wr(base, 3'd2, exp_conf(ch, gain), "R4");
        check_wr(base + 1, 3'd1, exp_mode(1, rate), "R4");
        if (good) begin
            check(!log_wr[base+2] && log_addr[base+2] == 3'd3, "R4", "data read",
                  {28'b0, log_wr[base+2], log_addr[base+2]}, 32'd3);
            check(nvalid == nv0 + 1 && last_data == {8'hC3, 8'(1 << ch), 8'h3C}, "R4",
                  "result", last_data, {8'hC3, 8'(1 << ch), 8'h3C});
        end else begin
            check_wr(base + 2, 3'd1, exp_mode(2, rate), "R8");
            check(nvalid == nv0, "R8", "no result strobe", 32'(nvalid), 32'(nv0));
            check(err == 1'b1, "R8", "err set", 32'(err), 32'd1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    int cur_rate, base;
    initial begin
        cur_rate = 480;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check(busy == 1'b1, "R3", "busy after reset", 32'(busy), 32'd1);
        check(err == 1'b0 && conv_valid == 1'b0, "R9", "clean flags",
              {err, conv_valid}, 32'd0);
        check(reg_req && reg_addr == 3'd1 && reg_wdata == exp_mode(2, 480), "R1",
              "first access", reg_wdata, exp_mode(2, 480));
        wait_idle();
        @(negedge clk);
        check(log_n == 19, "R2", "start-up access count", 32'(log_n), 32'd19);
        check_wr(0, 3'd1, exp_mode(2, 480), "R1");
        check_wr(1, 3'd2, exp_conf(-1, 0), "R1");
        sweep_expect(2, 0, 480, "R2");

        // Conversions on several channels
        do_conv(0, 0, 480, 1'b1);
        do_conv(3, 0, 480, 1'b1);
        do_conv(7, 0, 480, 1'b1);

        // Same gain: no traffic
        base = log_n;
        @(negedge clk); gain_val = 3'd0; gain_req = 1'b1;
        @(negedge clk); gain_req = 1'b0;
        check(busy == 1'b0, "R5", "same gain stays idle", 32'(busy), 32'd0);
        repeat (10) @(negedge clk);
        check(log_n == base, "R5", "same gain no access", 32'(log_n), 32'(base));

        // Gain change: conf write then sweep (last channel was 7)
        base = log_n;
        @(negedge clk); gain_val = 3'd3; gain_req = 1'b1;
        @(negedge clk); gain_req = 1'b0;
        check(busy == 1'b1, "R3", "busy during sweep", 32'(busy), 32'd1);
        wait_idle(); @(negedge clk);
        check(log_n - base == 18, "R5", "gain change count", 32'(log_n - base), 32'd18);
        check_wr(base, 3'd2, exp_conf(7, 3), "R5");
        sweep_expect(base + 1, 3, 480, "R5");

        // Filter-word table walk
        for (int v = 0; v < NVEC; v++) begin
            base = log_n;
            @(negedge clk); rate_val = RATE_VEC[v][12:1]; rate_req = 1'b1;
            @(negedge clk); rate_req = 1'b0;
            check(rate_rej == !RATE_VEC[v][0], "R6", $sformatf("reject flag %0d",
                  RATE_VEC[v][12:1]), 32'(rate_rej), 32'(!RATE_VEC[v][0]));
            wait_idle(); @(negedge clk);
            if (RATE_VEC[v][0]) begin
                cur_rate = int'(RATE_VEC[v][12:1]);
                check(log_n - base == 1, "R6", "accepted count", 32'(log_n - base), 32'd1);
                check_wr(base, 3'd1, exp_mode(2, cur_rate), "R6");
            end else begin
                check(log_n == base, "R6", "refused no access", 32'(log_n), 32'(base));
            end
        end
        do_conv(2, 3, cur_rate, 1'b1);   // R6: refused word did not leak

        // Request while busy
        base = log_n;
        @(negedge clk); gain_val = 3'd5; gain_req = 1'b1;
        @(negedge clk); gain_req = 1'b0;
        repeat (3) @(negedge clk);
        conv_chan = 3'd1; conv_req = 1'b1;
        @(negedge clk); conv_req = 1'b0;
        check(req_rej == 1'b1, "R7", "busy reject strobe", 32'(req_rej), 32'd1);
        wait_idle(); @(negedge clk);
        check(log_n - base == 18, "R7", "refused conversion ignored",
              32'(log_n - base), 32'd18);

        // Ready timeout
        suppress_rdy = 1'b1;
        do_conv(2, 5, cur_rate, 1'b0);
        check(busy == 1'b0, "R8", "idle after abort", 32'(busy), 32'd0);
        suppress_rdy = 1'b0;
        do_conv(1, 5, cur_rate, 1'b1);
        check(err == 1'b1, "R9", "err survives good conversion", 32'(err), 32'd1);

        // Reset clears err
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(err == 1'b0, "R9", "err cleared by reset", 32'(err), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule